// File: doc/BRIEF.md
# Queue-Limited In-Order Micro-Op Dispatcher

This block is the dispatch stage that sits between a micro-op source and the issue queues of an out-of-order core. Each cycle the source offers a window of up to three micro-ops, oldest in lane 0. Each micro-op carries a 3-bit tag naming the one dispatch queue it belongs to. The dispatcher walks the window strictly in order. It accepts micro-ops until the next one would push its queue past that queue's per-cycle allowance, or would make the cycle's total exceed three. At that point that micro-op and every younger one wait for the next cycle, which leaves a bubble in the dispatch slots.

Two floating-point queues, one per FP unit, each accept one micro-op per cycle. A combined FP queue accepts two per cycle, and every micro-op charged to either FP unit queue is charged to it as well. A micro-op tagged for the combined FP queue may be steered to either unit, and only the combined queue is charged for it. Because of these caps, a cycle can end after one or two micro-ops even when three are offered.

The per-lane ready outputs tell the source how many lanes were consumed, and the source shifts its window by that amount. The accepted micro-ops appear one cycle later as a registered dispatch vector, together with that cycle's count for every queue. Each queue count starts again from zero in every cycle.

Top module: `qdisp_top`

## Requirements
- R1: After reset, dispValid, dispTag, qCount and errFlag are all zero.
- R2: Dispatch is in order. inReady is always a prefix mask (lane i ready implies every lower lane ready), and dispValid is a prefix mask.
- R3: Tag encoding: 0 branch, 1 integer, 2 integer multi-cycle, 3 FP unit 0, 4 FP unit 1, 5 combined FP, 6 load/store, 7 reserved. The per-cycle caps are: branch 1, integer 2, integer multi-cycle 2, load/store 2.
- R4: FP unit 0 and FP unit 1 each accept at most 1 per cycle. Every micro-op tagged 3 or 4 also counts against the combined FP queue, whose cap is 2. A micro-op tagged 5 counts only against the combined FP queue.
- R5: The first valid micro-op that would exceed its queue cap, or a total of three, is not accepted, and no younger lane is accepted in that cycle.
- R6: A valid micro-op with tag 7 is accepted (ready) but is not dispatched and charges no queue. errFlag is 1 in the following cycle, and no younger lane is accepted in that cycle.
- R7: One cycle after a lane is accepted with a non-reserved tag, dispValid for that slot is 1 and dispTag bits [3i+2:3i] hold that tag.
- R8: qCount holds the counts of the previous cycle's dispatch, 2 bits per queue, with queue q (numbered as its tag) at bits [2q+1:2q]. The counts restart from zero every cycle.
- R9: A repeating stream of FP-unit-1, combined-FP, integer, integer, integer settles at 2 cycles per repetition.
- R10: A repeating stream of FP-unit-1, combined-FP, integer, integer settles at 4/3 cycles per repetition (4 cycles per 3 repetitions).
- R11: A lane whose inValid is 0 is never ready, and no lane above it is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 3 | Per-lane valid of the offered window, lane 0 oldest |
| inTag | input | 9 | Queue tag per lane, lane i at bits [3i+2:3i] |
| inReady | output | 3 | Per-lane accept for this cycle (prefix mask) |
| dispValid | output | 3 | Registered dispatch slots of the previous cycle |
| dispTag | output | 9 | Registered tags of the dispatched slots, zero where not valid |
| qCount | output | 14 | Per-queue counts of the previous cycle, 2 bits per queue |
| errFlag | output | 1 | A reserved tag was consumed in the previous cycle |

## Verification
The assertions check on every cycle that the ready and dispatch masks stay in prefix form, that no queue count goes over its cap, and that the combined FP count covers the two unit counts. They also check that the number of dispatched slots equals the number of queue charges, and that reserved tags and accepted lanes show up in the registered outputs one cycle later. Only the bench scenarios can show that the block accepts as many micro-ops as the caps allow, rather than merely staying within them. The same goes for the steady-state rates of the two repeating streams, which depend on how the caps interact over many cycles of a shifting window.

// File: rtl/qdisp_pkg.sv
package qdisp_pkg;
  localparam int DISP_W = 3;                 // micro-ops per cycle and lanes offered
  localparam int TAG_W  = 3;
  localparam int NUM_Q  = 7;                 // queues with a cap
  localparam int NUM_TAG = 1 << TAG_W;
  localparam int CNT_W  = $clog2(DISP_W + 1);

  typedef enum logic [TAG_W-1:0] {
    TAG_BR   = 3'd0,
    TAG_INT  = 3'd1,
    TAG_INTM = 3'd2,
    TAG_FP0  = 3'd3,
    TAG_FP1  = 3'd4,
    TAG_FPX  = 3'd5,
    TAG_MEM  = 3'd6,
    TAG_RSV  = 3'd7
  } qtag_e;

  function automatic int qLimit(input logic [TAG_W-1:0] q);
    case (q)
      TAG_BR:  return 1;
      TAG_INT: return 2;
      TAG_INTM: return 2;
      TAG_FP0: return 1;
      TAG_FP1: return 1;
      TAG_FPX: return 2;
      TAG_MEM: return 2;
      default: return 0;
    endcase
  endfunction

  typedef struct packed {
    logic [DISP_W-1:0]      takeMask;
    logic [DISP_W-1:0]      sendMask;
    logic                   errStb;
    logic [NUM_Q*CNT_W-1:0] qTally;
  } strobe_t;
endpackage

// File: rtl/qdisp_ctrl.sv
module qdisp_ctrl
  import qdisp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DISP_W-1:0]       inValid,
  input  logic [DISP_W*TAG_W-1:0] inTag,
  output strobe_t                 stb
);
  logic [CNT_W:0]    qCnt [NUM_TAG];
  logic [CNT_W:0]    total;
  logic              stopScan;
  logic              fits;
  logic [TAG_W-1:0]  laneTag;
  logic [DISP_W-1:0] take;
  logic [DISP_W-1:0] send;
  logic              err;

  always_comb begin
    for (int q = 0; q < NUM_TAG; q++) qCnt[q] = '0;
    total    = '0;
    stopScan = 1'b0;
    fits     = 1'b0;
    laneTag  = '0;
    take     = '0;
    send     = '0;
    err      = 1'b0;
    for (int i = 0; i < DISP_W; i++) begin
      laneTag = inTag[i*TAG_W +: TAG_W];
      if (!stopScan) begin
        if (!inValid[i]) begin
          stopScan = 1'b1;
        end else if (laneTag == TAG_RSV) begin
          take[i]  = 1'b1;
          err      = 1'b1;
          stopScan = 1'b1;
        end else begin
          fits = (int'(qCnt[laneTag]) + 1 <= qLimit(laneTag)) &&
                 (int'(total) < DISP_W);
          if (laneTag == TAG_FP0 || laneTag == TAG_FP1)
            fits = fits && (int'(qCnt[TAG_FPX]) + 1 <= qLimit(TAG_FPX));
          if (fits) begin
            take[i] = 1'b1;
            send[i] = 1'b1;
            qCnt[laneTag] = qCnt[laneTag] + 1'b1;
            if (laneTag == TAG_FP0 || laneTag == TAG_FP1)
              qCnt[TAG_FPX] = qCnt[TAG_FPX] + 1'b1;
            total = total + 1'b1;
          end else begin
            stopScan = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    stb.takeMask = take;
    stb.sendMask = send;
    stb.errStb   = err;
    for (int q = 0; q < NUM_Q; q++)
      stb.qTally[q*CNT_W +: CNT_W] = qCnt[q][CNT_W-1:0];
  end

  // R2: accepted lanes form a prefix
  p_ready_prefix_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeMask & (stb.takeMask + 1'b1)) == '0);

  // R11: no lane is taken without its valid
  p_ready_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeMask & ~inValid) == '0);
endmodule

// File: rtl/qdisp_data.sv
module qdisp_data
  import qdisp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [DISP_W*TAG_W-1:0] inTag,
  output logic [DISP_W-1:0]       dispValid,
  output logic [DISP_W*TAG_W-1:0] dispTag,
  output logic [NUM_Q*CNT_W-1:0]  qCount,
  output logic                    errFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispValid <= '0;
      dispTag   <= '0;
      qCount    <= '0;
      errFlag   <= 1'b0;
    end else begin
      dispValid <= stb.sendMask;
      for (int i = 0; i < DISP_W; i++)
        dispTag[i*TAG_W +: TAG_W] <= stb.sendMask[i] ? inTag[i*TAG_W +: TAG_W] : '0;
      qCount    <= stb.qTally;
      errFlag   <= stb.errStb;
    end
  end

  function automatic int fld(input logic [NUM_Q*CNT_W-1:0] v, input int q);
    return int'(v[q*CNT_W +: CNT_W]);
  endfunction

  // R3: non-FP queue caps
  p_queue_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    fld(qCount, TAG_BR) <= 1 && fld(qCount, TAG_INT) <= 2 &&
    fld(qCount, TAG_INTM) <= 2 && fld(qCount, TAG_MEM) <= 2);

  // R4: FP units charge the combined queue too
  p_fp_shared_r4: assert property (@(posedge clk) disable iff (!rstN)
    fld(qCount, TAG_FP0) <= 1 && fld(qCount, TAG_FP1) <= 1 &&
    fld(qCount, TAG_FPX) <= 2 &&
    fld(qCount, TAG_FPX) >= fld(qCount, TAG_FP0) + fld(qCount, TAG_FP1));

  // R8: slots and queue charges agree
  p_count_match_r8: assert property (@(posedge clk) disable iff (!rstN)
    $countones(dispValid) ==
      fld(qCount, TAG_BR) + fld(qCount, TAG_INT) + fld(qCount, TAG_INTM) +
      fld(qCount, TAG_FPX) + fld(qCount, TAG_MEM));

  // R2: dispatched slots form a prefix
  p_send_prefix_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid & (dispValid + 1'b1)) == '0);
endmodule

// File: rtl/qdisp_top.sv
module qdisp_top
  import qdisp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  inValid,
  input  logic [8:0]  inTag,
  output logic [2:0]  inReady,
  output logic [2:0]  dispValid,
  output logic [8:0]  dispTag,
  output logic [13:0] qCount,
  output logic        errFlag
);
  strobe_t stb;

  qdisp_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inTag(inTag), .stb(stb)
  );

  qdisp_data uData (
    .clk(clk), .rstN(rstN), .stb(stb), .inTag(inTag),
    .dispValid(dispValid), .dispTag(dispTag), .qCount(qCount), .errFlag(errFlag)
  );

  assign inReady = stb.takeMask;

  // R6: reserved tag in lane 0 flags an error and dispatches nothing
  p_err_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid[0] && inTag[2:0] == TAG_RSV) |=> (errFlag && dispValid == '0));

  // R7: an accepted lane 0 appears in slot 0 with its tag
  p_disp_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inReady[0] && inTag[2:0] != TAG_RSV) |=>
      (dispValid[0] && dispTag[2:0] == $past(inTag[2:0])));
endmodule

// File: tb/qdisp_top_test.sv
module qdisp_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  inValid = '0;
  logic [8:0]  inTag = '0;
  logic [2:0]  inReady, dispValid;
  logic [8:0]  dispTag;
  logic [13:0] qCount;
  logic        errFlag;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  qdisp_top uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference scan written from the requirements.
  function automatic void refScan(input logic [2:0] v, input logic [8:0] t,
                                  output logic [2:0] take, output logic [2:0] send,
                                  output logic err, output logic [13:0] tally);
    int cap [7] = '{1, 2, 2, 1, 1, 2, 2};
    int used [7] = '{0, 0, 0, 0, 0, 0, 0};
    int n = 0;
    bit halt = 0;
    take = '0; send = '0; err = 0; tally = '0;
    for (int i = 0; i < 3; i++) begin
      int tg = int'(t[3*i +: 3]);
      if (halt) continue;
      if (!v[i]) begin halt = 1; continue; end
      if (tg == 7) begin take[i] = 1; err = 1; halt = 1; continue; end
      if (used[tg] >= cap[tg] || n >= 3 ||
          ((tg == 3 || tg == 4) && used[5] >= cap[5])) begin
        halt = 1; continue;
      end
      used[tg]++; n++;
      if (tg == 3 || tg == 4) used[5]++;
      take[i] = 1; send[i] = 1;
    end
    for (int q = 0; q < 7; q++) tally[2*q +: 2] = 2'(used[q]);
  endfunction

  // Called at a negedge: drive, check ready, then registered outputs after the edge.
  task automatic apply(input string req, input logic [2:0] v, input logic [8:0] t);
    logic [2:0] eTake, eSend;
    logic eErr;
    logic [13:0] eTally;
    logic [8:0] eTag;
    refScan(v, t, eTake, eSend, eErr, eTally);
    eTag = '0;
    for (int i = 0; i < 3; i++) if (eSend[i]) eTag[3*i +: 3] = t[3*i +: 3];
    inValid = v; inTag = t;
    #1;
    check({req, " inReady"}, 32'(inReady), 32'(eTake));
    @(posedge clk); #1;
    check({req, " dispValid"}, 32'(dispValid), 32'(eSend));
    check({req, " dispTag"}, 32'(dispTag), 32'(eTag));
    check({req, " qCount"}, 32'(qCount), 32'(eTally));
    check({req, " errFlag"}, 32'(errFlag), 32'(eErr));
    @(negedge clk);
  endtask

  function automatic logic [8:0] tg3(input int a, input int b, input int c);
    return {3'(c), 3'(b), 3'(a)};
  endfunction

  logic [2:0] stream [512];

  // Feeds a repeating pattern and returns the cycles needed between two repetition marks.
  task automatic runPattern(input int plen, input int repA, input int repB, output int span);
    int ptr = 0, cyc = 0, cA = -1, cB = -1;
    int total = plen * (repB + 2);
    while (cB < 0 && cyc < 2000) begin
      for (int i = 0; i < 3; i++) begin
        inValid[i] = (ptr + i) < total;
        inTag[3*i +: 3] = ((ptr + i) < total) ? stream[(ptr + i) % plen] : 3'd0;
      end
      #1;
      ptr += $countones(inReady);
      @(posedge clk);
      cyc++;
      if (cA < 0 && ptr >= plen * repA) cA = cyc;
      if (cB < 0 && ptr >= plen * repB) cB = cyc;
      @(negedge clk);
    end
    inValid = '0;
    span = cB - cA;
  endtask

  initial begin
    int span;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 dispValid", 32'(dispValid), 0);
    check("R1 dispTag", 32'(dispTag), 0);
    check("R1 qCount", 32'(qCount), 0);
    check("R1 errFlag", 32'(errFlag), 0);
    rstN = 1'b1;
    @(negedge clk);

    apply("R3 three int stop at two", 3'b111, tg3(1, 1, 1));
    apply("R3 branch cap 1", 3'b111, tg3(0, 0, 1));
    apply("R3 loadstore cap 2", 3'b111, tg3(6, 6, 6));
    apply("R3 intm and mix fills three", 3'b111, tg3(2, 6, 1));
    apply("R4 fp0 fp1 then fp01 blocked", 3'b111, tg3(3, 4, 5));
    apply("R4 fp01 cap 2", 3'b111, tg3(5, 5, 5));
    apply("R4 fp0 twice", 3'b111, tg3(3, 3, 1));
    apply("R5 blocked lane stops younger", 3'b111, tg3(4, 4, 0));
    apply("R6 reserved mid window", 3'b111, tg3(1, 7, 1));
    apply("R6 reserved in lane 0", 3'b111, tg3(7, 1, 1));
    apply("R8 counts restart", 3'b001, tg3(1, 0, 0));
    apply("R11 hole in lane 0", 3'b110, tg3(1, 1, 1));
    apply("R11 hole in lane 1", 3'b101, tg3(2, 2, 2));
    apply("R7 single lane tag", 3'b001, tg3(6, 0, 0));

    for (int k = 0; k < 300; k++) begin
      logic [2:0] v = 3'($urandom_range(0, 7));
      logic [8:0] t = tg3($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7));
      apply("R2 R5 random window", v, t);
    end

    // R9: fp1, fp01, int x3
    stream[0] = 3'd4; stream[1] = 3'd5; stream[2] = 3'd1; stream[3] = 3'd1; stream[4] = 3'd1;
    runPattern(5, 40, 80, span);
    check("R9 cycles for 40 reps", 32'(span), 32'd80);

    // R10: fp1, fp01, int x2
    stream[0] = 3'd4; stream[1] = 3'd5; stream[2] = 3'd1; stream[3] = 3'd1;
    runPattern(4, 30, 60, span);
    check("R10 cycles for 30 reps", 32'(span), 32'd40);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule